// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure kept in ordinary memory. The linear address is split into three fields. The upper 10 bits pick an entry in a page directory, the next 10 bits pick an entry in a page table, and the low 12 bits are the byte offset inside a 4096-byte page. The physical page number of the directory comes from a control-register value that is presented on a dedicated input.

A client hands over one linear address with a valid/ready handshake. The walker then makes two dependent word reads on a simple memory read port. The first read fetches the directory entry and the second fetches the table entry. Each read stays posted until the memory returns data, so memory latency can be any length. The walk ends with a one-cycle response. That response carries either the physical address or a page-fault flag together with the linear address that faulted. A fault happens when either entry has its present bit clear. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: During and directly after a synchronous reset, `req_ready` is 1, and `mem_rd_req` and `rsp_valid` are 0.
- R2: A request is accepted only on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the walk returns to idle. Requests presented during that time are ignored.
- R3: In the cycle after acceptance, `mem_rd_req` is 1 and `mem_rd_addr` equals `{dir_base[31:12], req_vaddr[31:22], 2'b00}`, using the values sampled at acceptance.
- R4: When the directory entry returns with bit 0 (present) set, the next cycle issues the table read at `{entry[31:12], vaddr[21:12], 2'b00}`.
- R5: A posted read keeps `mem_rd_req` at 1 and `mem_rd_addr` unchanged until a cycle in which `mem_rd_data_valid` is 1, for any number of wait cycles. Read data is ignored while `mem_rd_data_valid` is 0.
- R6: When the table entry returns with bit 0 set, `rsp_valid` is 1 for exactly the next cycle with `rsp_fault` 0 and `rsp_paddr` = `{entry[31:12], vaddr[11:0]}`. Entry bits 11:1 have no effect.
- R7: When the directory entry returns with bit 0 clear, no table read is made. In the next cycle `rsp_valid` and `rsp_fault` are 1 and `rsp_fault_addr` equals the accepted linear address.
- R8: When the table entry returns with bit 0 clear, the next cycle gives `rsp_valid` and `rsp_fault` at 1, with `rsp_fault_addr` equal to the accepted linear address.
- R9: In the cycle after a response, `rsp_valid` is 0 and `req_ready` is 1.
- R10: A change of `dir_base` after acceptance has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_base | input | 32 | Control-register value; bits 31:12 are the directory page number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Linear address to translate |
| mem_rd_req | output | 1 | Word read posted |
| mem_rd_addr | output | 32 | Byte address of the word read |
| mem_rd_data_valid | input | 1 | Memory returns the word for the posted read |
| mem_rd_data | input | 32 | Returned entry word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Translated physical address (valid when no fault) |
| rsp_fault_addr | output | 32 | Linear address of the walk (meaningful on fault) |

## Verification
The assertions assume that memory raises `mem_rd_data_valid` only while `mem_rd_req` is 1, and exactly once per posted read. They also assume the client holds `req_valid` low in a response cycle if it does not want a new walk. The bench acts as the memory. It waits a chosen number of cycles for each read and then returns a single one-cycle data strobe. Between strobes it drives data words with every bit set. It drops `req_valid` before the walker comes back to idle, even in the runs where it keeps a different request and a new `dir_base` on the inputs during the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DIR   = 3'd1,
    ST_TBL   = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-OFS_W-1:0] pfn,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       slot_addr
);
  localparam int PAD_W = OFS_W - IDX_W - 2;

  generate
    if (PAD_W == 0) begin : g_tight
      assign slot_addr = {pfn, idx, 2'b00};
    end else begin : g_padded
      assign slot_addr = {pfn, {PAD_W{1'b0}}, idx, 2'b00};
    end
  endgenerate
endmodule

// File: rtl/ptw_req_capture.sv
module ptw_req_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] vaddr_in,
  output logic [ADDR_W-1:0] vaddr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vaddr_q <= '0;
    end else if (load) begin
      vaddr_q <= vaddr_in;
    end
  end
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              mem_rd_data_valid,
  input  logic              entry_present,
  input  logic [ADDR_W-1:0] dir_slot_addr,
  input  logic [ADDR_W-1:0] tbl_slot_addr,
  input  logic [ADDR_W-1:0] frame_addr,
  output logic              accept,
  output logic              req_ready,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr
);
  walk_state_e state_q, state_d;
  logic        dir_hit, tbl_hit;

  assign accept  = req_valid && (state_q == ST_IDLE);
  assign dir_hit = (state_q == ST_DIR) && mem_rd_data_valid;
  assign tbl_hit = (state_q == ST_TBL) && mem_rd_data_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept)  state_d = ST_DIR;
      ST_DIR:   if (dir_hit) state_d = entry_present ? ST_TBL  : ST_FAULT;
      ST_TBL:   if (tbl_hit) state_d = entry_present ? ST_DONE : ST_FAULT;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_ready   <= 1'b1;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_paddr   <= '0;
    end else begin
      state_q    <= state_d;
      req_ready  <= (state_d == ST_IDLE);
      mem_rd_req <= (state_d == ST_DIR) || (state_d == ST_TBL);
      rsp_valid  <= (state_d == ST_DONE) || (state_d == ST_FAULT);
      rsp_fault  <= (state_d == ST_FAULT);
      if (accept) begin
        mem_rd_addr <= dir_slot_addr;
      end else if (dir_hit && entry_present) begin
        mem_rd_addr <= tbl_slot_addr;
      end
      if (tbl_hit && entry_present) begin
        rsp_paddr <= frame_addr;
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int ADDR_W      = 32,
  parameter int DIR_W       = 10,
  parameter int TBL_W       = 10,
  parameter int PRESENT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_data_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] rsp_fault_addr
);
  localparam int OFS_W = ADDR_W - DIR_W - TBL_W;
  localparam int PFN_W = ADDR_W - OFS_W;

  logic              accept;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] dir_slot_addr;
  logic [ADDR_W-1:0] tbl_slot_addr;
  logic [ADDR_W-1:0] frame_addr;
  logic              unused_low_bits;

  assign unused_low_bits = ^{dir_base[OFS_W-1:0], mem_rd_data[OFS_W-1:0]};

  ptw_req_capture #(.ADDR_W(ADDR_W)) cap_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .vaddr_in (req_vaddr),
    .vaddr_q  (va_q)
  );

  ptw_entry_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(DIR_W)) dir_slot_i (
    .pfn       (dir_base[ADDR_W-1 -: PFN_W]),
    .idx       (req_vaddr[ADDR_W-1 -: DIR_W]),
    .slot_addr (dir_slot_addr)
  );

  ptw_entry_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(TBL_W)) tbl_slot_i (
    .pfn       (mem_rd_data[ADDR_W-1 -: PFN_W]),
    .idx       (va_q[OFS_W +: TBL_W]),
    .slot_addr (tbl_slot_addr)
  );

  assign frame_addr = {mem_rd_data[ADDR_W-1 -: PFN_W], va_q[OFS_W-1:0]};

  ptw_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk               (clk),
    .rst               (rst),
    .req_valid         (req_valid),
    .mem_rd_data_valid (mem_rd_data_valid),
    .entry_present     (mem_rd_data[PRESENT_BIT]),
    .dir_slot_addr     (dir_slot_addr),
    .tbl_slot_addr     (tbl_slot_addr),
    .frame_addr        (frame_addr),
    .accept            (accept),
    .req_ready         (req_ready),
    .mem_rd_req        (mem_rd_req),
    .mem_rd_addr       (mem_rd_addr),
    .rsp_valid         (rsp_valid),
    .rsp_fault         (rsp_fault),
    .rsp_paddr         (rsp_paddr)
  );

  assign rsp_fault_addr = va_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W      = 32,
  parameter int DIR_W       = 10,
  parameter int TBL_W       = 10,
  parameter int PRESENT_BIT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] dir_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_data_valid,
  input logic [ADDR_W-1:0] mem_rd_data,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] rsp_fault_addr
);
  localparam int OFS_W = ADDR_W - DIR_W - TBL_W;
  localparam logic [ADDR_W-1:0] HI_MASK  = {ADDR_W{1'b1}} << OFS_W;
  localparam logic [ADDR_W-1:0] LO_MASK  = ~HI_MASK;
  localparam logic [ADDR_W-1:0] TBL_MASK = {{(ADDR_W-TBL_W){1'b0}}, {TBL_W{1'b1}}};

  logic [ADDR_W-1:0] va_seen;
  logic              on_table;
  logic              fire;
  logic              ret;

  assign fire = req_valid && req_ready;
  assign ret  = mem_rd_req && mem_rd_data_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      va_seen  <= '0;
      on_table <= 1'b0;
    end else begin
      if (fire) begin
        va_seen  <= req_vaddr;
        on_table <= 1'b0;
      end else if (ret) begin
        on_table <= !on_table && mem_rd_data[PRESENT_BIT];
      end
    end
  end

  function automatic logic [ADDR_W-1:0] slot(input logic [ADDR_W-1:0] base_word,
                                             input logic [ADDR_W-1:0] index);
    return (base_word & HI_MASK) | (index << 2);
  endfunction

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_rd_req && !rsp_valid));

  a_r3_dir_slot: assert property (@(posedge clk) disable iff (rst)
    fire |=> (mem_rd_req &&
              mem_rd_addr == slot($past(dir_base), $past(req_vaddr) >> (ADDR_W - DIR_W))));

  a_r4_tbl_slot: assert property (@(posedge clk) disable iff (rst)
    (ret && !on_table && mem_rd_data[PRESENT_BIT]) |=>
      (mem_rd_req && mem_rd_addr == slot($past(mem_rd_data), (va_seen >> OFS_W) & TBL_MASK)));

  a_r5_hold_read: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_data_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> ((rsp_paddr & LO_MASK) == (va_seen & LO_MASK)));

  a_r6_table_hit: assert property (@(posedge clk) disable iff (rst)
    (ret && on_table && mem_rd_data[PRESENT_BIT]) |=> (rsp_valid && !rsp_fault && !mem_rd_req));

  a_r7_dir_fault: assert property (@(posedge clk) disable iff (rst)
    (ret && !on_table && !mem_rd_data[PRESENT_BIT]) |=> (rsp_valid && rsp_fault && !mem_rd_req));

  a_r8_tbl_fault: assert property (@(posedge clk) disable iff (rst)
    (ret && on_table && !mem_rd_data[PRESENT_BIT]) |=> (rsp_valid && rsp_fault));

  a_r7_fault_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_fault_addr == va_seen));

  a_r9_back_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (req_ready && !rsp_valid));
endmodule

bind ptw_walker ptw_walker_chk #(
  .ADDR_W(ADDR_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .PRESENT_BIT(PRESENT_BIT)
) chk_i (
  .clk               (clk),
  .rst               (rst),
  .dir_base          (dir_base),
  .req_valid         (req_valid),
  .req_ready         (req_ready),
  .req_vaddr         (req_vaddr),
  .mem_rd_req        (mem_rd_req),
  .mem_rd_addr       (mem_rd_addr),
  .mem_rd_data_valid (mem_rd_data_valid),
  .mem_rd_data       (mem_rd_data),
  .rsp_valid         (rsp_valid),
  .rsp_fault         (rsp_fault),
  .rsp_paddr         (rsp_paddr),
  .rsp_fault_addr    (rsp_fault_addr)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dir_base = 32'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = 32'h0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_data_valid = 1'b0;
  logic [31:0] mem_rd_data = 32'hFFFF_FFFF;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_fault_addr;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [19:0] BASE_A = 20'h00010;
  localparam logic [19:0] BASE_B = 20'h00033;

  always #4 clk = ~clk;

  ptw_walker dut_i (
    .clk               (clk),
    .rst               (rst),
    .dir_base          (dir_base),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .req_vaddr         (req_vaddr),
    .mem_rd_req        (mem_rd_req),
    .mem_rd_addr       (mem_rd_addr),
    .mem_rd_data_valid (mem_rd_data_valid),
    .mem_rd_data       (mem_rd_data),
    .rsp_valid         (rsp_valid),
    .rsp_fault         (rsp_fault),
    .rsp_paddr         (rsp_paddr),
    .rsp_fault_addr    (rsp_fault_addr)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory image: directory at the chosen base page, tables at pages 0x40000+d.
  function automatic logic [31:0] dir_entry(input logic [9:0] d);
    logic present;
    present = (int'(d) % 7) != 3;
    return {10'h100, d, 1'b0, d, present};
  endfunction

  function automatic logic [31:0] tbl_entry(input logic [9:0] d, input logic [9:0] i);
    logic        present;
    logic [19:0] frame;
    present = ((int'(d) + int'(i)) % 11) != 5;
    frame   = {d, i} ^ 20'h5A5A5;
    return {frame, ~i, 1'b1, present};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [19:0] base_pfn);
    if (a[31:12] == base_pfn)    return dir_entry(a[11:2]);
    else if (a[31:22] == 10'h100) return tbl_entry(a[21:12], a[11:2]);
    else                          return 32'hDEAD_BEE0;
  endfunction

  task automatic serve(input logic [31:0] word);
    mem_rd_data_valid = 1'b1;
    mem_rd_data       = word;
    @(negedge clk);
    mem_rd_data_valid = 1'b0;
    mem_rd_data       = 32'hFFFF_FFFF;
  endtask

  task automatic walk(input logic [31:0] va, input logic [19:0] base_pfn,
                      input int lat1, input int lat2, input bit disturb);
    logic [31:0] exp_dir, exp_tbl, pde, pte, exp_pa;
    exp_dir = {base_pfn, va[31:22], 2'b00};
    pde     = mem_word(exp_dir, base_pfn);
    exp_tbl = {pde[31:12], va[21:12], 2'b00};
    pte     = mem_word(exp_tbl, base_pfn);
    exp_pa  = {pte[31:12], va[11:0]};

    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'h1);
    dir_base  = {base_pfn, 12'h0};
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    if (disturb) begin
      req_vaddr = ~va;            // R2 busy request must be ignored
      dir_base  = 32'hFFFF_F000;  // R10 late base change must not matter
    end else begin
      req_valid = 1'b0;
    end
    check(req_ready == 1'b0, "R2 busy after accept", 32'(req_ready), 32'h0);
    check(mem_rd_req && mem_rd_addr == exp_dir, "R3 directory read", mem_rd_addr, exp_dir);
    for (int k = 0; k < lat1; k++) begin
      @(negedge clk);
      check(mem_rd_req && mem_rd_addr == exp_dir, "R5 directory read held", mem_rd_addr, exp_dir);
    end
    serve(pde);
    if (!pde[0]) begin
      req_valid = 1'b0;
      check(!mem_rd_req, "R7 no table read", 32'(mem_rd_req), 32'h0);
      check(rsp_valid && rsp_fault, "R7 directory fault flag",
            {30'h0, rsp_valid, rsp_fault}, 32'h3);
      check(rsp_fault_addr == va, "R7 fault address", rsp_fault_addr, va);
    end else begin
      check(mem_rd_req && mem_rd_addr == exp_tbl, "R4 table read", mem_rd_addr, exp_tbl);
      for (int k = 0; k < lat2; k++) begin
        @(negedge clk);
        check(mem_rd_req && mem_rd_addr == exp_tbl, "R5 table read held", mem_rd_addr, exp_tbl);
      end
      serve(pte);
      req_valid = 1'b0;
      if (pte[0]) begin
        check(rsp_valid && !rsp_fault, "R6 success flag",
              {30'h0, rsp_valid, rsp_fault}, 32'h2);
        check(rsp_paddr == exp_pa, disturb ? "R6 R10 physical address" : "R6 physical address",
              rsp_paddr, exp_pa);
      end else begin
        check(rsp_valid && rsp_fault, "R8 table fault flag",
              {30'h0, rsp_valid, rsp_fault}, 32'h3);
        check(rsp_fault_addr == va, "R8 fault address", rsp_fault_addr, va);
      end
    end
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 back to idle",
          {30'h0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !mem_rd_req && !rsp_valid, "R1 state in reset",
          {29'h0, req_ready, mem_rd_req, rsp_valid}, 32'h4);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !mem_rd_req && !rsp_valid, "R1 state after reset",
          {29'h0, req_ready, mem_rd_req, rsp_valid}, 32'h4);

    // Every directory slot, mixed table slots, offsets, latencies and bases.
    for (int d = 0; d < 1024; d++) begin
      logic [9:0]  di, ti;
      logic [11:0] of;
      di = 10'(d);
      ti = 10'((d * 37 + 11) % 1024);
      of = 12'((d * 291) % 4096);
      walk({di, ti, of}, (d % 3 == 1) ? BASE_B : BASE_A, d % 4, (d / 4) % 3, (d % 5) == 0);
    end

    // Every table slot under one present directory entry.
    for (int t = 0; t < 1024; t++) begin
      logic [9:0] ti;
      ti = 10'(t);
      walk({10'd6, ti, 12'(t * 5 + 3)}, BASE_A, t % 2, t % 3, (t % 7) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule